// File: doc/BRIEF.md
# Nibble Mailbox Command Controller

This block is an I/O peripheral that a host CPU shares through a sixteen-entry register file, four bits per entry. The host places a command code in entry 8 and any arguments in entries 9 to 15. It then pulses a run strobe. The controller carries out the command and leaves its results in entries 0 to 7, where the host reads them back. Reads return the stored nibble with the upper four bits set.

The commands are:
- a raw sample of four active-low switch ports, which also updates two output ports;
- loading coinage settings for two coin slots;
- firing a one-cycle request to a separate coin/credit unit;
- a fixed boot-check answer;
- a nibble-sum checksum;
- a two-phase multiplexed switch scan.

For the scan, the controller drives a select output low and waits a settling time before it captures. It then drives the select high, waits again and captures a second time. A busy flag stays high from the cycle after the strobe until the last result is written.

Top module: `nibble_cmd_ctrl`

## Requirements
- R1: After reset, every register nibble reads 0, both output ports are 0, all four coinage settings are 1, busy is 0 and the coin request is 0.
- R2: A host write stores only bits 3:0 of the write data at hostAddr. A host read returns {4'hF, nibble at hostAddr} combinationally.
- R3: A run strobe seen while idle latches the command code from nibble 8 and raises busy from the next cycle. Single-step commands hold busy for exactly one cycle. While busy, run strobes and host writes are ignored.
- R4: Code 1 stores the inverse of ports A, B, C and D in nibbles 0, 1, 2 and 3. It also drives output A with nibble 9 and output B with nibble 10.
- R5: Code 2 loads slot-0 ratio from nibble 9 and slot-0 credits from nibble 10. It loads slot-1 ratio from nibble 11 and slot-1 credits from nibble 12.
- R6: Code 4 raises coinGo for exactly one cycle, in the busy cycle, and changes no register nibble.
- R7: Code 7 writes 0xE into nibble 2 and 0x6 into nibble 7.
- R8: Code 8 adds nibbles 9 to 15 into an 8-bit sum. It writes sum bits 7:4 to nibble 0 and bits 3:0 to nibble 1.
- R9: Code 9 drives output A to 0 and waits SETTLE_CYC+1 cycles. It then stores the inverse of ports A, B, C and D in nibbles 0, 2, 4 and 6, and drives output A to 1 in the same cycle. After another SETTLE_CYC+1 cycles it stores the inverted ports in nibbles 1, 3, 5 and 7. Busy lasts 2*SETTLE_CYC+3 cycles, and output A stays 1 afterwards.
- R10: Any other code (for example 0 or 3) takes one busy cycle and changes no nibble, output port or coinage setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 4 | Host register-file address |
| hostWrData | input | 8 | Host write data (low nibble kept) |
| hostWrEn | input | 1 | Host write enable |
| hostRdData | output | 8 | Host read data, upper nibble forced to 0xF |
| runStrobe | input | 1 | Start command held in nibble 8 |
| busy | output | 1 | Command in progress |
| inA | input | 4 | Switch port A, active low |
| inB | input | 4 | Switch port B, active low |
| inC | input | 4 | Switch port C, active low |
| inD | input | 4 | Switch port D, active low |
| outA | output | 4 | Output port A, also the scan select |
| outB | output | 4 | Output port B |
| coinGo | output | 1 | One-cycle request to the coin/credit unit |
| coinRatio0 | output | 4 | Slot-0 coins-per-credit setting |
| coinCredit0 | output | 4 | Slot-0 credits-per-coin setting |
| coinRatio1 | output | 4 | Slot-1 coins-per-credit setting |
| coinCredit1 | output | 4 | Slot-1 credits-per-coin setting |

## Verification
The bench builds the block with SETTLE_CYC = 3 instead of the default 2. This stretches each scan phase to four cycles and the whole scan to nine busy cycles, which leaves room to poke the run strobe and a host write in the middle of a command. The switch inputs are modelled as a multiplexer steered by bit 0 of output A. Each scan half can therefore capture only the pattern that matches the select level it was taken under. This exposes any capture taken in the wrong phase or before the select has changed.

// File: rtl/nmb_pkg.sv
package nmb_pkg;
  localparam int NIB_W   = 4;
  localparam int DEPTH   = 16;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int N_PORTS = 4;
  localparam int SUM_W   = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    CMD_SWITCH  = 4'd1,
    CMD_COINCFG = 4'd2,
    CMD_COIN    = 4'd4,
    CMD_BOOTFIX = 4'd7,
    CMD_SUM     = 4'd8,
    CMD_SCAN    = 4'd9
  } cmdCode_e;

  typedef struct packed {
    logic wrSwitch;
    logic loadCoin;
    logic coinGo;
    logic wrBoot;
    logic wrSum;
    logic selLow;
    logic selHigh;
    logic capEven;
    logic capOdd;
  } dpStrobe_t;
endpackage

// File: rtl/nmb_datapath.sv
module nmb_datapath
  import nmb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             hostAddr,
  input  logic [NIB_W-1:0]              hostWrNib,
  input  logic                          hostWe,
  output logic [NIB_W-1:0]              hostRdNib,
  input  dpStrobe_t                     strobe,
  input  logic [N_PORTS-1:0][NIB_W-1:0] inPorts,
  output logic [NIB_W-1:0]              cmdNib,
  output logic [NIB_W-1:0]              outA,
  output logic [NIB_W-1:0]              outB,
  output logic [NIB_W-1:0]              ratio0,
  output logic [NIB_W-1:0]              credit0,
  output logic [NIB_W-1:0]              ratio1,
  output logic [NIB_W-1:0]              credit1
);
  localparam int ARG0 = 9;

  logic [NIB_W-1:0] regFile [DEPTH];
  logic [SUM_W-1:0] nibSum;

  always_comb begin
    nibSum = '0;
    for (int i = ARG0; i < DEPTH; i++) nibSum = nibSum + SUM_W'(regFile[i]);
  end

  assign hostRdNib = regFile[hostAddr];
  assign cmdNib    = regFile[8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
      outA    <= '0;
      outB    <= '0;
      ratio0  <= NIB_W'(1);
      credit0 <= NIB_W'(1);
      ratio1  <= NIB_W'(1);
      credit1 <= NIB_W'(1);
    end else begin
      if (hostWe) regFile[hostAddr] <= hostWrNib;
      if (strobe.wrSwitch) begin
        for (int k = 0; k < N_PORTS; k++) regFile[k] <= ~inPorts[k];
        outA <= regFile[ARG0];
        outB <= regFile[ARG0+1];
      end
      if (strobe.loadCoin) begin
        ratio0  <= regFile[ARG0];
        credit0 <= regFile[ARG0+1];
        ratio1  <= regFile[ARG0+2];
        credit1 <= regFile[ARG0+3];
      end
      if (strobe.wrBoot) begin
        regFile[2] <= 4'hE;
        regFile[7] <= 4'h6;
      end
      if (strobe.wrSum) begin
        regFile[0] <= nibSum[SUM_W-1:NIB_W];
        regFile[1] <= nibSum[NIB_W-1:0];
      end
      if (strobe.selLow)  outA <= '0;
      if (strobe.selHigh) outA <= NIB_W'(1);
      if (strobe.capEven)
        for (int k = 0; k < N_PORTS; k++) regFile[2*k] <= ~inPorts[k];
      if (strobe.capOdd)
        for (int k = 0; k < N_PORTS; k++) regFile[2*k+1] <= ~inPorts[k];
    end
  end

  p_even_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capEven |-> (outA == '0));
  p_odd_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capOdd |-> (outA == NIB_W'(1)));
  p_sum_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSum |=> (regFile[0] <= 4'd6));
  p_host_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostWe |=> (regFile[$past(hostAddr)] == $past(hostWrNib)));
endmodule

// File: rtl/nmb_control.sv
module nmb_control
  import nmb_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runStrobe,
  input  logic [NIB_W-1:0] cmdNib,
  output logic             busy,
  output dpStrobe_t        strobe
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_WAITLO, ST_WAITHI} state_e;

  state_e           state, nextState;
  logic [NIB_W-1:0] cmdQ;
  logic [CNT_W-1:0] cnt;

  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (runStrobe) nextState = ST_DECODE;
      ST_DECODE: begin
        nextState = ST_IDLE;
        case (cmdQ)
          CMD_SWITCH:  strobe.wrSwitch = 1'b1;
          CMD_COINCFG: strobe.loadCoin = 1'b1;
          CMD_COIN:    strobe.coinGo   = 1'b1;
          CMD_BOOTFIX: strobe.wrBoot   = 1'b1;
          CMD_SUM:     strobe.wrSum    = 1'b1;
          CMD_SCAN: begin
            strobe.selLow = 1'b1;
            nextState     = ST_WAITLO;
          end
          default: ;
        endcase
      end
      ST_WAITLO: if (cnt == '0) begin
        strobe.capEven  = 1'b1;
        strobe.selHigh  = 1'b1;
        nextState       = ST_WAITHI;
      end
      ST_WAITHI: if (cnt == '0) begin
        strobe.capOdd = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cmdQ  <= '0;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && runStrobe) cmdQ <= cmdNib;
      if (strobe.selLow || strobe.capEven) cnt <= CNT_W'(SETTLE_CYC);
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  p_run_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runStrobe && !busy) |=> busy);
  p_coin_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.coinGo |=> !strobe.coinGo);
  p_scan_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capOdd |=> !busy);
endmodule

// File: rtl/nibble_cmd_ctrl.sv
module nibble_cmd_ctrl
  import nmb_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] hostAddr,
  input  logic [7:0] hostWrData,
  input  logic       hostWrEn,
  output logic [7:0] hostRdData,
  input  logic       runStrobe,
  output logic       busy,
  input  logic [3:0] inA,
  input  logic [3:0] inB,
  input  logic [3:0] inC,
  input  logic [3:0] inD,
  output logic [3:0] outA,
  output logic [3:0] outB,
  output logic       coinGo,
  output logic [3:0] coinRatio0,
  output logic [3:0] coinCredit0,
  output logic [3:0] coinRatio1,
  output logic [3:0] coinCredit1
);
  dpStrobe_t                     strobe;
  logic [NIB_W-1:0]              cmdNib, hostRdNib;
  logic [N_PORTS-1:0][NIB_W-1:0] inPorts;

  assign inPorts    = {inD, inC, inB, inA};
  assign hostRdData = {4'hF, hostRdNib};
  assign coinGo     = strobe.coinGo;

  nmb_control #(.SETTLE_CYC(SETTLE_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .runStrobe(runStrobe), .cmdNib(cmdNib),
    .busy(busy), .strobe(strobe)
  );

  nmb_datapath dp_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrNib(hostWrData[3:0]),
    .hostWe(hostWrEn && !busy), .hostRdNib(hostRdNib), .strobe(strobe),
    .inPorts(inPorts), .cmdNib(cmdNib), .outA(outA), .outB(outB),
    .ratio0(coinRatio0), .credit0(coinCredit0),
    .ratio1(coinRatio1), .credit1(coinCredit1)
  );
endmodule

// File: tb/nibble_cmd_ctrl_tb.sv
module nibble_cmd_ctrl_tb_top;
  localparam int SETTLE = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostRdData;
  logic       runStrobe = 1'b0;
  logic       busy;
  logic [3:0] inA, inB, inC, inD, outA, outB;
  logic       coinGo;
  logic [3:0] coinRatio0, coinCredit0, coinRatio1, coinCredit1;
  logic [15:0] loPat = '0, hiPat = '0;

  int checks = 0, failures = 0, cycles = 0;
  int busyCnt, coinCnt;

  always #10 clk = ~clk;

  always_comb {inA, inB, inC, inD} = outA[0] ? hiPat : loPat;

  nibble_cmd_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (.*);

  // nibble-sum vectors: {nib9..nib15, expected sum}
  localparam logic [35:0] SUM_VEC [5] = '{
    {28'h0000000, 8'h00}, {28'hFFFFFFF, 8'h69}, {28'h1234567, 8'h1C},
    {28'h9876543, 8'h2A}, {28'hF0F0F0F, 8'h3C}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic readNib(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); hostAddr = a; #1 d = hostRdData;
  endtask

  task automatic chkNib(input string tag, input logic [3:0] a, input logic [3:0] exp);
    logic [7:0] d;
    readNib(a, d);
    chk(tag, d, {4'hF, exp});
  endtask

  task automatic runCmd(input logic [3:0] code, input bit poke);
    hostWrite(4'd8, {4'h0, code});
    @(negedge clk); runStrobe = 1'b1;
    @(negedge clk); runStrobe = 1'b0;
    busyCnt = 0; coinCnt = 0;
    while (busy && busyCnt < 100) begin
      busyCnt++;
      if (coinGo) coinCnt++;
      if (poke && busyCnt == 2) begin
        runStrobe = 1'b1; hostAddr = 4'd12; hostWrData = 8'h05; hostWrEn = 1'b1;
      end else begin
        runStrobe = 1'b0; hostWrEn = 1'b0;
      end
      @(negedge clk);
    end
    runStrobe = 1'b0; hostWrEn = 1'b0;
    if (coinGo) coinCnt++;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 50000) begin
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int i = 0; i < 16; i++) chkNib("R1 reset nibble", 4'(i), 4'h0);
    chk("R1 outA", outA, 0); chk("R1 outB", outB, 0);
    chk("R1 ratio0", coinRatio0, 1); chk("R1 credit0", coinCredit0, 1);
    chk("R1 ratio1", coinRatio1, 1); chk("R1 credit1", coinCredit1, 1);
    chk("R1 busy", busy, 0); chk("R1 coinGo", coinGo, 0);

    // R2 low nibble kept, upper read as F
    hostWrite(4'd13, 8'h5A);
    chkNib("R2 write low nibble", 4'd13, 4'hA);

    // R8 checksum vectors
    for (int v = 0; v < 5; v++) begin
      for (int n = 0; n < 7; n++)
        hostWrite(4'(9 + n), {4'h0, SUM_VEC[v][35 - 4*n -: 4]});
      runCmd(4'd8, 1'b0);
      chk("R3 single-step busy", busyCnt, 1);
      chkNib("R8 sum high", 4'd0, SUM_VEC[v][7:4]);
      chkNib("R8 sum low", 4'd1, SUM_VEC[v][3:0]);
    end

    // R4 switch read and outputs
    hostWrite(4'd9, 8'h0C); hostWrite(4'd10, 8'h05);
    loPat = 16'h1248; hiPat = 16'h1248;
    runCmd(4'd1, 1'b0);
    chkNib("R4 nib0", 4'd0, 4'hE); chkNib("R4 nib1", 4'd1, 4'hD);
    chkNib("R4 nib2", 4'd2, 4'hB); chkNib("R4 nib3", 4'd3, 4'h7);
    chk("R4 outA", outA, 4'hC); chk("R4 outB", outB, 4'h5);

    // R5 coinage load
    hostWrite(4'd9, 8'h03); hostWrite(4'd10, 8'h02);
    hostWrite(4'd11, 8'h0B); hostWrite(4'd12, 8'h04);
    runCmd(4'd2, 1'b0);
    chk("R5 ratio0", coinRatio0, 3); chk("R5 credit0", coinCredit0, 2);
    chk("R5 ratio1", coinRatio1, 4'hB); chk("R5 credit1", coinCredit1, 4);

    // R6 coin request pulse
    runCmd(4'd4, 1'b0);
    chk("R6 coinGo cycles", coinCnt, 1);
    chkNib("R6 nib0 untouched", 4'd0, 4'hE);

    // R7 boot answer
    runCmd(4'd7, 1'b0);
    chkNib("R7 nib2", 4'd2, 4'hE); chkNib("R7 nib7", 4'd7, 4'h6);

    // R9 two-phase scan, with R3 poke mid-command
    loPat = 16'h3569; hiPat = 16'hA0F7;
    runCmd(4'd9, 1'b1);
    chk("R9 busy length", busyCnt, 2*SETTLE + 3);
    chk("R9 outA high after", outA, 4'h1);
    chkNib("R9 nib0", 4'd0, 4'hC); chkNib("R9 nib2", 4'd2, 4'hA);
    chkNib("R9 nib4", 4'd4, 4'h9); chkNib("R9 nib6", 4'd6, 4'h6);
    chkNib("R9 nib1", 4'd1, 4'h5); chkNib("R9 nib3", 4'd3, 4'hF);
    chkNib("R9 nib5", 4'd5, 4'h0); chkNib("R9 nib7", 4'd7, 4'h8);
    chkNib("R3 write dropped while busy", 4'd12, 4'h4);
    chk("R3 strobe ignored while busy", busy, 0);

    // R10 unknown codes
    loPat = 16'hFFFF; hiPat = 16'hFFFF;
    runCmd(4'd3, 1'b0);
    chk("R10 code3 busy", busyCnt, 1);
    runCmd(4'd0, 1'b0);
    chkNib("R10 nib0", 4'd0, 4'hC); chkNib("R10 nib3", 4'd3, 4'hF);
    chkNib("R10 nib7", 4'd7, 4'h8);
    chk("R10 outA", outA, 4'h1); chk("R10 outB", outB, 4'h5);
    chk("R10 ratio0", coinRatio0, 3); chk("R10 credit1", coinCredit1, 4);
    readNib(4'd8, d);
    chk("R2 read upper F", d, 8'hF0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule